// File: doc/BRIEF.md
# Ethernet Receive Frame Error Tagger

This block sits between a 64-bit MAC receive datapath and a client that consumes frames over a ready/valid stream. Incoming beats carry data, start and end markers, an empty-byte count, a per-beat line error flag, and two end-of-frame flags: CRC mismatch and payload length error. The block forwards each beat unchanged. It measures the frame length as it goes, and on the final beat of each frame it attaches a 6-bit error vector built from the flags it has gathered and from the length.

The receive source cannot be stalled. A two-entry output buffer absorbs short pauses by the client. When a beat arrives and no slot is free, the beat and the rest of its frame are discarded. The frame is then closed by a synthetic end beat with the overflow bit set, sent as soon as space frees up. A start beat that arrives while a frame is still open closes the open frame early with a synthetic end beat that flags a line error.

Top module: `rxt_err_tagger`

## Requirements
- R1: Each forwarded beat keeps its data, start and end markers. The first byte on the wire is in bits 63:56. A beat taken in at one clock edge is shown on the output after that edge.
- R2: `out_empty` equals the input empty count on end beats and is 0 on all other beats. `out_err` is 0 on every beat that is not an end beat.
- R3: While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R4: Error bit 0 is set on the end beat when any forwarded beat of the frame had `in_line_err` high.
- R5: Error bit 1 copies `in_crc_bad` and bit 4 copies `in_len_err`, both sampled on the end beat.
- R6: The frame length is 8 bytes per beat minus the empty count of the end beat. Error bit 2 is set when this length is below 64 bytes.
- R7: Error bit 3 is set when the frame length is above `MAX_FRAME` (default 1518).
- R8: A beat that arrives when the buffer has no room is dropped, along with all later beats of its frame. A synthetic end beat then follows the frame's forwarded beats. It has zero data, empty 0 and error bits 5 set, bit 0 set if a line error was seen, and all other bits 0. Its start marker is set only when no beat of the frame was forwarded.
- R9: The gathered flags and the length are restarted by every forwarded start beat.
- R10: A start beat that arrives while a frame is open is preceded on the output by a synthetic end beat for the open frame. That beat has zero data, empty 0, no start marker and error vector 6'b000001.
- R11: Beats without a start marker that arrive while no frame is open are ignored.
- R12: Reset (active-low, synchronous) clears `out_valid`. A frame that starts while a synthetic end beat is still waiting for space is discarded in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present (cannot be stalled) |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | 64 | Beat data, first byte in bits 63:56 |
| in_empty | input | 3 | Unused bytes in the end beat |
| in_line_err | input | 1 | Line-level error on this beat |
| in_crc_bad | input | 1 | CRC mismatch, meaningful on end beat |
| in_len_err | input | 1 | Payload length error, meaningful on end beat |
| out_ready | input | 1 | Client can accept a beat |
| out_valid | output | 1 | Output beat present |
| out_sop | output | 1 | Output first-beat marker |
| out_eop | output | 1 | Output last-beat marker |
| out_data | output | 64 | Output beat data |
| out_empty | output | 3 | Unused bytes in the output end beat |
| out_err | output | 6 | Per-frame error vector, end beat only |

## Verification
The assertions assume that `in_empty`, `in_crc_bad` and `in_len_err` only matter when `in_valid` and `in_eop` are both high. They also assume that the client may hold `out_ready` low for any number of cycles. The stimulus changes inputs one time unit after each rising edge and holds them until the next edge. It drives those end-only fields to zero on other beats and idles `in_valid` between frames. The client's ready is held steady over whole stall windows, so the buffer fills and the overflow and early-start paths are reached on purpose rather than by chance.

// File: rtl/rxt_pkg.sv
// Shared widths, error-bit positions and the buffered beat type for the
// receive frame error tagger. Assumes a 64-bit data path only.
package rxt_pkg;
    localparam int DATA_W  = 64;
    localparam int EMPTY_W = 3;
    localparam int ERR_W   = 6;
    localparam int BYTES_PER_BEAT = DATA_W / 8;

    // Error vector bit positions (the client decodes these)
    localparam int ERR_LINE  = 0;
    localparam int ERR_CRC   = 1;
    localparam int ERR_SHORT = 2;
    localparam int ERR_LONG  = 3;
    localparam int ERR_PLEN  = 4;
    localparam int ERR_OVF   = 5;

    typedef struct packed {
        logic               sop;
        logic               eop;
        logic [EMPTY_W-1:0] empty;
        logic [ERR_W-1:0]   err;
        logic [DATA_W-1:0]  data;
    } beat_t;
endpackage

// File: rtl/rxt_frame_acc.sv
// Per-frame accumulator: counts forwarded bytes and remembers line errors,
// and forms the end-of-frame error vector from them and the end-beat flags.
// Assumes adv is high only for beats that are actually forwarded.
module rxt_frame_acc
    import rxt_pkg::*;
#(
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               sop,
    input  logic [EMPTY_W-1:0] empty,
    input  logic               line_err,
    input  logic               crc_bad,
    input  logic               len_err,
    output logic [ERR_W-1:0]   eop_err,
    output logic               line_seen
);
    localparam int LW  = $clog2(MAX_FRAME + 32);
    localparam int CAP = MAX_FRAME + 9;

    logic [LW-1:0] cnt_q, cnt_eff;
    logic          line_q, line_eff;
    int            total;

    // Restart the gathered state on a start beat (R9)
    always_comb begin
        cnt_eff  = sop ? '0 : cnt_q;
        line_eff = sop ? 1'b0 : line_q;
        line_seen = line_eff | line_err;
        total = int'(cnt_eff) + BYTES_PER_BEAT - int'(empty);
    end

    // Form the error vector presented with an end beat
    always_comb begin
        eop_err = '0;
        eop_err[ERR_LINE]  = line_seen;
        eop_err[ERR_CRC]   = crc_bad;
        eop_err[ERR_SHORT] = (total < MIN_FRAME);
        eop_err[ERR_LONG]  = (total > MAX_FRAME);
        eop_err[ERR_PLEN]  = len_err;
    end

    // Advance the saturating byte count and line-error memory per forwarded beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_q <= 1'b0;
        end else if (adv) begin
            cnt_q  <= (int'(cnt_eff) >= CAP) ? LW'(CAP) : cnt_eff + LW'(BYTES_PER_BEAT);
            line_q <= line_seen;
        end
    end

    // R9: a forwarded start beat leaves exactly one beat of bytes counted
    a_r9_sop_restart: assert property (@(posedge clk) disable iff (!rst_n)
        adv && sop |=> cnt_q == LW'(BYTES_PER_BEAT));

    // R4: a forwarded line error is remembered for the rest of the frame
    a_r4_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
        adv && line_err |=> line_q);
endmodule

// File: rtl/rxt_out_fifo.sv
// Small output buffer that can take two beats in one cycle (a synthetic end
// beat followed by an input beat). Assumes the writer never exceeds free space
// and that push_b is used only together with push_a.
module rxt_out_fifo
    import rxt_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_a,
    input  beat_t                        beat_a,
    input  logic                         push_b,
    input  beat_t                        beat_b,
    input  logic                         pop,
    output beat_t                        head,
    output logic                         not_empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    beat_t         mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q, wr_b;

    // Second write slot follows the first, wrapping at DEPTH
    always_comb wr_b = PW'((int'(wr_q) + 1) % DEPTH);

    // Store pushed beats
    always_ff @(posedge clk) begin
        if (push_a) mem[wr_q] <= beat_a;
        if (push_b) mem[wr_b] <= beat_b;
    end

    // Move pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= '0;
        end else begin
            wr_q  <= PW'((int'(wr_q) + int'(push_a) + int'(push_b)) % DEPTH);
            if (pop) rd_q <= PW'((int'(rd_q) + 1) % DEPTH);
            count <= CW'(int'(count) + int'(push_a) + int'(push_b) - int'(pop));
        end
    end

    assign head      = mem[rd_q];
    assign not_empty = (count != '0);

    // R8: the buffer never holds more than its depth
    a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R10: a second push in one cycle always rides behind a first one
    a_r10_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        push_b |-> push_a);
endmodule

// File: rtl/rxt_admit.sv
// Admission control: decides per cycle which beats enter the output buffer,
// inserts synthetic end beats for overflowed and early-ended frames, and
// tracks whether a frame is open or being discarded. Assumes the input can
// never be stalled.
module rxt_admit
    import rxt_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sop,
    input  logic                       in_eop,
    input  logic [DATA_W-1:0]          in_data,
    input  logic [EMPTY_W-1:0]         in_empty,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       pop,
    input  logic [ERR_W-1:0]           eop_err,
    input  logic                       line_seen,
    output logic                       adv,
    output logic                       push_a,
    output beat_t                      beat_a,
    output logic                       push_b,
    output beat_t                      beat_b
);
    logic             open_q, drop_q, force_q, force_sop_q;
    logic [ERR_W-1:0] force_err_q;

    logic  s_force, s_close, s_req, s_go, blocked;
    logic  i_req, i_go, i_ovf, i_silent;
    int    space;
    beat_t synth, inb;

    // Decide which synthetic and input beats fit this cycle
    always_comb begin
        space    = DEPTH - int'(count) + int'(pop);
        s_force  = force_q;
        s_close  = !force_q && in_valid && in_sop && open_q && !drop_q;
        s_req    = s_force || s_close;
        s_go     = s_req && (space >= 1);
        blocked  = s_req && !s_go;
        i_req    = in_valid && (in_sop || (open_q && !drop_q));
        i_go     = i_req && !blocked && ((space - int'(s_go)) >= 1);
        i_ovf    = i_req && !blocked && !i_go;
        i_silent = i_req && blocked;
        adv      = i_go;
    end

    // Assemble the synthetic end beat and the forwarded input beat
    always_comb begin
        synth       = '0;
        synth.eop   = 1'b1;
        synth.sop   = s_force ? force_sop_q : 1'b0;
        synth.err   = s_force ? force_err_q : ERR_W'(1) << ERR_LINE;
        inb.sop     = in_sop;
        inb.eop     = in_eop;
        inb.data    = in_data;
        inb.empty   = in_eop ? in_empty : '0;
        inb.err     = in_eop ? eop_err : '0;
    end

    // Route beats to the two buffer write slots, synthetic beat first
    always_comb begin
        push_a = s_go ? 1'b1 : i_go;
        beat_a = s_go ? synth : inb;
        push_b = s_go && i_go;
        beat_b = inb;
    end

    // Track pending synthetic end beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q     <= 1'b0;
            force_sop_q <= 1'b0;
            force_err_q <= '0;
        end else if (i_ovf) begin
            force_q     <= 1'b1;
            force_sop_q <= in_sop;
            force_err_q <= (ERR_W'(1) << ERR_OVF) | (ERR_W'(line_seen) << ERR_LINE);
        end else if (blocked && s_close) begin
            force_q     <= 1'b1;
            force_sop_q <= 1'b0;
            force_err_q <= ERR_W'(1) << ERR_LINE;
        end else if (s_go && s_force) begin
            force_q     <= 1'b0;
        end
    end

    // Track the open and discarding state of the input frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            drop_q <= 1'b0;
        end else if (i_go) begin
            open_q <= !in_eop;
            drop_q <= 1'b0;
        end else if (i_ovf || i_silent) begin
            open_q <= !in_eop;
            drop_q <= !in_eop;
        end else if (in_valid && open_q && drop_q && in_eop) begin
            open_q <= 1'b0;
            drop_q <= 1'b0;
        end
    end

    // R8: an overflow always leaves a synthetic end beat pending
    a_r8_force_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        i_ovf |=> force_q);

    // R11: stray non-start beats outside a frame never enter the buffer
    a_r11_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_sop && !open_q && !force_q |-> !push_a);
endmodule

// File: rtl/rxt_err_tagger.sv
// Top of the receive frame error tagger: forwards 64-bit receive beats to a
// ready/valid client and tags each frame's end beat with a 6-bit error vector.
// Assumes the upstream source cannot be back-pressured.
module rxt_err_tagger
    import rxt_pkg::*;
#(
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 64,
    parameter int DEPTH     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [63:0]        in_data,
    input  logic [2:0]         in_empty,
    input  logic               in_line_err,
    input  logic               in_crc_bad,
    input  logic               in_len_err,
    input  logic               out_ready,
    output logic               out_valid,
    output logic               out_sop,
    output logic               out_eop,
    output logic [63:0]        out_data,
    output logic [2:0]         out_empty,
    output logic [5:0]         out_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             adv, push_a, push_b, pop, not_empty, line_seen;
    logic [ERR_W-1:0] eop_err;
    logic [CW-1:0]    count;
    beat_t            beat_a, beat_b, head;

    rxt_frame_acc #(.MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME)) u_acc (
        .clk(clk), .rst_n(rst_n), .adv(adv), .sop(in_sop), .empty(in_empty),
        .line_err(in_line_err), .crc_bad(in_crc_bad), .len_err(in_len_err),
        .eop_err(eop_err), .line_seen(line_seen)
    );

    rxt_admit #(.DEPTH(DEPTH)) u_admit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_empty(in_empty),
        .count(count), .pop(pop), .eop_err(eop_err), .line_seen(line_seen),
        .adv(adv), .push_a(push_a), .beat_a(beat_a), .push_b(push_b), .beat_b(beat_b)
    );

    rxt_out_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_a(push_a), .beat_a(beat_a),
        .push_b(push_b), .beat_b(beat_b), .pop(pop), .head(head),
        .not_empty(not_empty), .count(count)
    );

    // Present the buffer head to the client
    always_comb begin
        pop       = not_empty && out_ready;
        out_valid = not_empty;
        out_sop   = head.sop;
        out_eop   = head.eop;
        out_data  = head.data;
        out_empty = head.empty;
        out_err   = head.err;
    end

    // R2: error vector only on end beats
    a_r2_err_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_eop |-> out_err == '0);

    // R2: empty count only on end beats
    a_r2_empty_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_eop |-> out_empty == '0);

    // R3: a stalled beat is held unchanged
    a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err)
            && $stable(out_sop) && $stable(out_eop) && $stable(out_empty));

    // R8: an overflow-tagged beat is a zero-data end beat
    a_r8_ovf_beat_shape: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err[ERR_OVF] |-> out_eop && out_data == '0 && out_empty == '0);
endmodule

// File: tb/rxt_err_tagger_tb.sv
module rxt_err_tagger_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 9;
    localparam int CAPN  = 1024;

    // Row: [26:21] expected err, [20] len_err, [19] crc, [18:16] empty,
    //      [15:8] beat index carrying a line error (FF = none), [7:0] beats
    localparam logic [26:0] VEC [NROWS] = '{
        {6'b000000, 1'b0, 1'b0, 3'd0, 8'hFF, 8'd8},
        {6'b000100, 1'b0, 1'b0, 3'd1, 8'hFF, 8'd8},
        {6'b000000, 1'b0, 1'b0, 3'd2, 8'hFF, 8'd190},
        {6'b001000, 1'b0, 1'b0, 3'd1, 8'hFF, 8'd190},
        {6'b000001, 1'b0, 1'b0, 3'd0, 8'd3,  8'd10},
        {6'b000010, 1'b0, 1'b1, 3'd0, 8'hFF, 8'd10},
        {6'b010000, 1'b1, 1'b0, 3'd0, 8'hFF, 8'd10},
        {6'b000110, 1'b0, 1'b1, 3'd0, 8'hFF, 8'd1},
        {6'b000011, 1'b0, 1'b1, 3'd4, 8'd11, 8'd12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_sop = 0, in_eop = 0, in_line_err = 0, in_crc_bad = 0, in_len_err = 0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_empty = '0;
    logic out_ready = 1'b1;
    logic out_valid, out_sop, out_eop;
    logic [63:0] out_data;
    logic [2:0]  out_empty;
    logic [5:0]  out_err;

    int nchk = 0, nerr = 0, mid_bad = 0, cap_n = 0;
    logic        cap_sop [CAPN];
    logic        cap_eop [CAPN];
    logic [63:0] cap_data [CAPN];
    logic [2:0]  cap_empty [CAPN];
    logic [5:0]  cap_err [CAPN];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxt_err_tagger u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_empty(in_empty), .in_line_err(in_line_err),
        .in_crc_bad(in_crc_bad), .in_len_err(in_len_err), .out_ready(out_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
        .out_empty(out_empty), .out_err(out_err)
    );

    // Record every beat the client accepts (transfer at the following edge)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < CAPN) begin
            cap_sop[cap_n]   = out_sop;
            cap_eop[cap_n]   = out_eop;
            cap_data[cap_n]  = out_data;
            cap_empty[cap_n] = out_empty;
            cap_err[cap_n]   = out_err;
            if (!out_eop && (out_err != 0 || out_empty != 0)) mid_bad++;
            cap_n++;
        end
    end

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic e, input logic [63:0] d, input logic [2:0] emp,
                         input logic le, input logic crc, input logic len);
        @(posedge clk); #1;
        in_valid = 1; in_sop = s; in_eop = e; in_data = d; in_empty = emp;
        in_line_err = le; in_crc_bad = crc; in_len_err = len;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 0; in_sop = 0; in_eop = 0; in_data = '0; in_empty = '0;
            in_line_err = 0; in_crc_bad = 0; in_len_err = 0;
        end
    endtask

    function automatic logic [63:0] pat(input int id, input int k);
        return {8'(id), 8'(k), 48'h0011_2233_4455};
    endfunction

    task automatic send_frame(input int id, input int beats, input logic [2:0] emp,
                              input int lineb, input logic crc, input logic len, input logic with_eop);
        for (int k = 0; k < beats; k++) begin
            logic last;
            last = (k == beats - 1) && with_eop;
            drive(k == 0, last, pat(id, k), last ? emp : 3'd0, k == lineb,
                  last ? crc : 1'b0, last ? len : 1'b0);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++; nchk++;
        $display("FAIL watchdog R1 actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R12 reset out_valid", 64'(out_valid), 0);

        // Table walk: client always ready
        for (int r = 0; r < NROWS; r++) begin
            int beats, lineb;
            logic [5:0] exp_err;
            logic [2:0] emp;
            beats = int'(VEC[r][7:0]);
            lineb = (VEC[r][15:8] == 8'hFF) ? -1 : int'(VEC[r][15:8]);
            emp = VEC[r][18:16];
            exp_err = VEC[r][26:21];
            base = cap_n;
            send_frame(r + 1, beats, emp, lineb, VEC[r][19], VEC[r][20], 1'b1);
            idle(3);
            chk(cap_n - base == beats, "R1 beat count", 64'(cap_n - base), 64'(beats));
            chk(cap_sop[base] && cap_data[base] == pat(r + 1, 0), "R1 first beat data/sop",
                cap_data[base], pat(r + 1, 0));
            chk(cap_data[base][63:56] == 8'(r + 1), "R1 first byte lane", 64'(cap_data[base][63:56]), 64'(r + 1));
            chk(cap_eop[cap_n-1] && cap_err[cap_n-1] == exp_err,
                "R4 R5 R6 R7 R9 end-beat error vector", 64'(cap_err[cap_n-1]), 64'(exp_err));
            chk(cap_empty[cap_n-1] == emp, "R2 end-beat empty", 64'(cap_empty[cap_n-1]), 64'(emp));
        end
        chk(mid_bad == 0, "R2 non-end beats carry no err/empty", 64'(mid_bad), 0);

        // R3: stall with two buffered beats
        @(posedge clk); #1 out_ready = 0;
        base = cap_n;
        send_frame(20, 2, 3'd0, -1, 0, 0, 1'b1);
        idle(1);
        @(negedge clk);
        chk(out_valid && out_sop && out_data == pat(20, 0), "R3 stalled head", out_data, pat(20, 0));
        repeat (3) @(negedge clk);
        chk(out_valid && out_data == pat(20, 0), "R3 held while stalled", out_data, pat(20, 0));
        @(posedge clk); #1 out_ready = 1;
        idle(4);
        chk(cap_n - base == 2 && cap_data[base+1] == pat(20, 1), "R3 drained in order",
            64'(cap_n - base), 2);

        // R8: overflow in mid frame
        @(posedge clk); #1 out_ready = 0;
        base = cap_n;
        send_frame(21, 4, 3'd0, -1, 0, 0, 1'b1);
        idle(2);
        @(posedge clk); #1 out_ready = 1;
        idle(5);
        chk(cap_n - base == 3, "R8 rest of frame dropped", 64'(cap_n - base), 3);
        chk(cap_eop[base+2] && !cap_sop[base+2] && cap_err[base+2] == 6'b100000 && cap_data[base+2] == 0,
            "R8 forced end beat", 64'(cap_err[base+2]), 64'(6'b100000));

        // R8: overflow on a whole new one-beat frame with a line error
        @(posedge clk); #1 out_ready = 0;
        base = cap_n;
        send_frame(22, 2, 3'd0, -1, 0, 0, 1'b1);
        drive(1, 1, pat(23, 0), 3'd0, 1, 0, 0);
        idle(2);
        @(posedge clk); #1 out_ready = 1;
        idle(5);
        chk(cap_n - base == 3, "R8 count with new-frame overflow", 64'(cap_n - base), 3);
        chk(cap_sop[base+2] && cap_eop[base+2] && cap_err[base+2] == 6'b100001,
            "R8 forced beat with sop and line error", 64'(cap_err[base+2]), 64'(6'b100001));

        // R10: start beat while a frame is open
        base = cap_n;
        send_frame(24, 3, 3'd0, -1, 0, 0, 1'b0);
        send_frame(25, 8, 3'd0, -1, 0, 0, 1'b1);
        idle(4);
        chk(cap_n - base == 12, "R10 beat count", 64'(cap_n - base), 12);
        chk(cap_eop[base+3] && !cap_sop[base+3] && cap_err[base+3] == 6'b000001 && cap_data[base+3] == 0,
            "R10 closing beat", 64'(cap_err[base+3]), 1);
        chk(cap_sop[base+4] && cap_data[base+4] == pat(25, 0), "R10 new frame follows", cap_data[base+4], pat(25, 0));
        chk(cap_err[base+11] == 0, "R9 flags cleared for new frame", 64'(cap_err[base+11]), 0);

        // R11: stray beats with no open frame
        base = cap_n;
        drive(0, 0, pat(26, 0), 3'd0, 1, 0, 0);
        drive(0, 1, pat(26, 1), 3'd2, 0, 1, 0);
        idle(4);
        chk(cap_n == base, "R11 stray beats ignored", 64'(cap_n - base), 0);

        // R12: reset clears a buffered beat
        @(posedge clk); #1 out_ready = 0;
        drive(1, 0, pat(27, 0), 3'd0, 0, 0, 0);
        idle(1);
        @(negedge clk);
        chk(out_valid == 1, "R12 beat buffered before reset", 64'(out_valid), 1);
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R12 reset clears output", 64'(out_valid), 0);

        report();
        $finish;
    end
endmodule